// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between an on-chip requester and one external asynchronous static RAM of 128K bytes that has a single shared 8-bit data bus. Each request is a single beat: a read or a write of one byte at a 17-bit address. The controller turns the request into a timed sequence of chip select, write enable and output enable (all active low), drives the address, and controls a tri-state data driver through a separate enable, so the pad ring can build the bidirectional bus.

Every phase of an access lasts a whole number of clock cycles set by a parameter. The parameters are chosen from the clock period so that each minimum of the memory (setup before the write strobe, strobe width, access time, bus turnaround) is met by rounding up. The request side uses valid/ready: a request transfers on a cycle where both are high. The requester may hold `req_valid` high for as long as it likes; while `req_ready` is low it must keep the request fields steady, and nothing is taken. Read data comes back as a one-cycle pulse on `rd_valid` with no back-pressure, so the requester must be able to take it at any time.

A retention input parks the memory in its low-power state: chip select stays high and no access starts. When retention is released, a recovery count runs before the first new request is taken.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` and `rd_valid` are low, and `req_ready` is high while `ret_req` is low.
- R2: A request transfers only on a cycle with `req_valid` and `req_ready` both high; `req_ready` then stays low until the whole access, including its trailing phase, is over.
- R3: A write first drives address and data (`mem_dq_oe` high) with `mem_cs_n` high for SETUP_CYC cycles, then holds `mem_cs_n` and `mem_we_n` low together for exactly WR_CYC cycles.
- R4: Across the write strobe, `mem_addr` equals the request address and `mem_dq_out` the request data, both unchanged; `mem_dq_oe` stays high for HOLD_CYC cycles after the strobe ends and is low once the controller is ready again.
- R5: `mem_oe_n` is never low while `mem_we_n` is low.
- R6: A read holds `mem_cs_n` and `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` low for exactly ACCESS_CYC cycles, samples `mem_dq_in` in the last of them, and in the next cycle presents that byte on `rd_data` with `rd_valid` high for one cycle.
- R7: After a read, chip select and output enable stay high with the driver off for TURN_CYC cycles before another access; `mem_dq_oe` is never high while both `mem_cs_n` and `mem_oe_n` are low.
- R8: While `ret_req` is high and no access is in flight, `req_ready` is low and `mem_cs_n` is high; a request offered then has no effect on memory contents.
- R9: After `ret_req` falls, `req_ready` stays low for exactly RECOVER_CYC cycles and then rises.
- R10: Raising `ret_req` during an access does not cut it short: the write strobe still lasts WR_CYC cycles and the data lands.
- R11: `rd_valid` pulses exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, read byte valid |
| rd_data | output | 8 | Read byte |
| ret_req | input | 1 | Level request for retention mode |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Byte read back from the data bus |

## Verification
The bench builds the block with SETUP_CYC=2, WR_CYC=3, HOLD_CYC=1, ACCESS_CYC=2, TURN_CYC=1 and RECOVER_CYC=20. Phases longer than one cycle make an off-by-one in any phase counter visible as a wrong count of strobe cycles, and a short recovery count brings the full retention exit within a few dozen cycles instead of half a million. A behavioural memory in the bench commits bytes only at the end of the chip-select/write-enable overlap and returns a distinct filler byte whenever the memory is not reading, so a sample taken outside the access window shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_STROBE,
    ST_WR_HOLD,
    ST_RD_ACCESS,
    ST_RD_TURN,
    ST_RETAIN,
    ST_RECOVER
  } sc_state_e;

  // Pin-level strobe set, all strobes active low, driver enable active high.
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } sc_pins_t;

  localparam sc_pins_t PINS_PARKED = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Asserted during the final cycle of the loaded phase.
  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned WR_CYC      = 1,
  parameter int unsigned HOLD_CYC    = 1,
  parameter int unsigned ACCESS_CYC  = 2,
  parameter int unsigned TURN_CYC    = 1,
  parameter int unsigned RECOVER_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             ret_req,
  input  logic             phase_last,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output sc_pins_t         pins
);

  sc_state_e state_q, state_d;
  sc_pins_t  pins_q;

  function automatic sc_pins_t decode(input sc_state_e st);
    sc_pins_t p;
    p = PINS_PARKED;
    case (st)
      ST_WR_SETUP:  p.dq_oe = 1'b1;
      ST_WR_STROBE: begin
        p.cs_n  = 1'b0;
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WR_HOLD:   p.dq_oe = 1'b1;
      ST_RD_ACCESS: begin
        p.cs_n = 1'b0;
        p.oe_n = 1'b0;
      end
      default:      p = PINS_PARKED;
    endcase
    return p;
  endfunction

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    req_ready = (state_q == ST_IDLE) && !ret_req;
    case (state_q)
      ST_IDLE: begin
        if (ret_req) begin
          state_d = ST_RETAIN;
        end else if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            tmr_val = CNT_W'(SETUP_CYC);
          end else begin
            state_d = ST_RD_ACCESS;
            tmr_val = CNT_W'(ACCESS_CYC);
          end
        end
      end
      ST_WR_SETUP: begin
        if (phase_last) begin
          state_d  = ST_WR_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WR_CYC);
        end
      end
      ST_WR_STROBE: begin
        if (phase_last) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC);
        end
      end
      ST_WR_HOLD: begin
        if (phase_last) state_d = ST_IDLE;
      end
      ST_RD_ACCESS: begin
        if (phase_last) begin
          capture  = 1'b1;
          state_d  = ST_RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TURN_CYC);
        end
      end
      ST_RD_TURN: begin
        if (phase_last) state_d = ST_IDLE;
      end
      ST_RETAIN: begin
        if (!ret_req) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RECOVER_CYC);
        end
      end
      ST_RECOVER: begin
        if (phase_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state, so they change exactly
  // with the state register and never glitch at the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= PINS_PARKED;
    end else begin
      state_q <= state_d;
      pins_q  <= decode(state_d);
    end
  end

  assign pins = pins_q;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  // Address and write data are captured once per request and held
  // unchanged until the next request is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rd_valid   = rvalid_q;
  assign rd_data    = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned WR_CYC      = 1,
  parameter int unsigned HOLD_CYC    = 1,
  parameter int unsigned ACCESS_CYC  = 2,
  parameter int unsigned TURN_CYC    = 1,
  parameter int unsigned RECOVER_CYC = 500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ret_req,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned MAX_CYC = umax(umax(umax(SETUP_CYC, WR_CYC), umax(HOLD_CYC, ACCESS_CYC)),
                                         umax(TURN_CYC, RECOVER_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_last;
  sc_pins_t         pins;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (phase_last)
  );

  sram_ctrl_fsm #(
    .CNT_W       (CNT_W),
    .SETUP_CYC   (SETUP_CYC),
    .WR_CYC      (WR_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .ACCESS_CYC  (ACCESS_CYC),
    .TURN_CYC    (TURN_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .ret_req    (ret_req),
    .phase_last (phase_last),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .pins       (pins)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign mem_cs_n  = pins.cs_n;
  assign mem_we_n  = pins.we_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_dq_oe = pins.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WR_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ret_req,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              rd_valid
);

  int unsigned we_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_len <= 0;
    else if (!mem_we_n) we_len <= we_len + 1;
    else               we_len <= 0;
  end

  assert_handshake_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_len == WR_CYC));

  assert_write_fields_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  assert_oe_we_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_single_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_cs_n || mem_oe_n));

  assert_retain_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> !req_ready);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WR_CYC (WR_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ret_req    (ret_req),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .rd_valid   (rd_valid)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int P_SETUP = 2;
  localparam int P_WR    = 3;
  localparam int P_HOLD  = 1;
  localparam int P_ACC   = 2;
  localparam int P_TURN  = 1;
  localparam int P_REC   = 20;
  localparam logic [DW-1:0] FILL = 8'hEE;

  // {write, address, write byte, expected read byte}
  localparam int NVEC = 8;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
    {1'b1, 17'h00010, 8'hFF, 8'h00},
    {1'b1, 17'h00010, 8'h00, 8'h00},
    {1'b0, 17'h00010, 8'h00, 8'h00},
    {1'b0, 17'h00033, 8'h00, 8'h69}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          ret_req = 1'b0;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int n_checks = 0;
  int n_fails  = 0;
  int n_reads  = 0;
  int n_pulses = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  sram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(P_SETUP), .WR_CYC(P_WR), .HOLD_CYC(P_HOLD),
    .ACCESS_CYC(P_ACC), .TURN_CYC(P_TURN), .RECOVER_CYC(P_REC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ret_req(ret_req),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory: bytes land when the cs/we overlap ends.
  logic [DW-1:0] mem [256];
  bit            wr_open = 0;
  logic [7:0]    wr_a;
  logic [DW-1:0] wr_d;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      wr_open = 1;
      wr_a    = mem_addr[7:0];
      wr_d    = mem_dq_oe ? mem_dq_out : FILL;
    end else if (wr_open) begin
      mem[wr_a] = wr_d;
      wr_open   = 0;
    end
    if (rd_valid) n_pulses++;
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : FILL;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic offer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n_setup = 0, n_strobe = 0, n_hold = 0, bad_fld = 0, oe_bad = 0, pulses0;
    bit seen = 0;
    @(negedge clk);
    offer(1'b1, a, d);
    pulses0 = n_pulses;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      if (req_ready) break;
      if (!mem_cs_n && !mem_we_n) begin
        seen = 1;
        n_strobe++;
        if (mem_addr != a || mem_dq_out != d || !mem_dq_oe) bad_fld++;
        if (!mem_oe_n) oe_bad++;
      end else if (mem_cs_n && mem_dq_oe) begin
        if (seen) n_hold++; else n_setup++;
      end
    end
    check(n_setup == P_SETUP, "R3 setup cycles", n_setup, P_SETUP);
    check(n_strobe == P_WR, "R3 strobe cycles", n_strobe, P_WR);
    check(bad_fld == 0, "R4 fields during strobe", bad_fld, 0);
    check(n_hold == P_HOLD, "R4 hold cycles", n_hold, P_HOLD);
    check(!mem_dq_oe, "R4 driver off when ready", mem_dq_oe, 0);
    check(oe_bad == 0, "R5 oe low during write", oe_bad, 0);
    check(n_pulses == pulses0, "R11 no rd_valid on write", n_pulses - pulses0, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int n_acc = 0, n_turn = 0, n_val = 0, cont = 0;
    logic [DW-1:0] got = '0;
    bit acc_done = 0;
    @(negedge clk);
    offer(1'b0, a, '0);
    n_reads++;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      if (mem_dq_oe && !mem_cs_n && !mem_oe_n) cont++;
      if (rd_valid) begin
        n_val++;
        got = rd_data;
      end
      if (req_ready) break;
      if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe) n_acc++;
      else if (mem_cs_n && mem_oe_n && !mem_dq_oe) begin
        acc_done = 1;
        n_turn++;
      end
    end
    check(n_acc == P_ACC, "R6 access cycles", n_acc, P_ACC);
    check(n_val == 1, "R11 one rd_valid per read", n_val, 1);
    check(got == exp, "R6 read data", got, exp);
    check(acc_done && n_turn == P_TURN, "R7 turnaround cycles", n_turn, P_TURN);
    check(cont == 0, "R7 bus contention", cont, 0);
  endtask

  initial begin
    #(1_000_000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    int csbad;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high after reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe && !rd_valid, "R1 driver and rd_valid low", {mem_dq_oe, rd_valid}, 0);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][33]) do_write(VEC[v][32:16], VEC[v][15:8]);
      else            do_read(VEC[v][32:16], VEC[v][7:0]);
    end

    // R2: ready low throughout a write, request not retaken
    @(negedge clk);
    offer(1'b1, 17'h00044, 8'h12);
    @(negedge clk);
    check(!req_ready, "R2 ready low after accept", req_ready, 0);
    cnt = 0;
    for (int c = 0; c < 50 && !req_ready; c++) begin
      cnt++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(cnt == P_SETUP + P_WR + P_HOLD, "R2 busy length", cnt, P_SETUP + P_WR + P_HOLD);
    do_read(17'h00044, 8'h12);

    // R8/R9: retention blocks requests, then recovery count
    @(negedge clk);
    ret_req = 1'b1;
    #1;
    check(!req_ready, "R8 ready low in retention", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'h11;
    csbad = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (!mem_cs_n || req_ready) csbad++;
    end
    check(csbad == 0, "R8 cs high and ready low", csbad, 0);
    req_valid = 1'b0;
    ret_req = 1'b0;
    cnt = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (req_ready) break;
      cnt++;
    end
    check(cnt == P_REC, "R9 recovery length", cnt, P_REC);
    do_read(17'h00000, 8'hA5);

    // R10: retention raised mid-write does not abort it
    @(negedge clk);
    offer(1'b1, 17'h00020, 8'h77);
    cnt = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (c == 0) begin req_valid = 1'b0; ret_req = 1'b1; end
      if (!mem_cs_n && !mem_we_n) cnt++;
    end
    check(cnt == P_WR, "R10 strobe kept", cnt, P_WR);
    check(mem_cs_n && !req_ready, "R8 parked after write", {mem_cs_n, req_ready}, 2'b10);
    ret_req = 1'b0;
    for (int c = 0; c < 100 && !req_ready; c++) @(negedge clk);
    do_read(17'h00020, 8'h77);

    // Back-to-back: read then write with no gap offered
    do_read(17'h1FFFF, 8'h3C);
    do_write(17'h1FFFF, 8'hC3);
    do_read(17'h1FFFF, 8'hC3);

    repeat (3) @(negedge clk);
    check(n_pulses == n_reads, "R11 total rd_valid pulses", n_pulses, n_reads);
    finish_run();
  end

endmodule